// File: doc/BRIEF.md
# Double-Rate Receive Capture for Reduced-Pin Gigabit Links

This block sits on the MAC side of a reduced-pin gigabit receive link. The link has four data lines, one control line and a receive clock, and carries two samples per clock period: one at the rising edge and one at the falling edge. The block captures both samples and pairs each rising-edge sample with the falling-edge sample that follows it. On the next rising edge it presents the pair as one single-rate word in the receive clock domain. The receive clock runs at 125 MHz, 25 MHz or 2.5 MHz.

A format input selects the meaning of the lines. In the byte format, the rising half carries the low nibble and the data-valid flag, and the falling half carries the high nibble and data-valid XOR error. The outputs are then a byte, a valid strobe, an error flag and a carrier/idle indication. In the ten-bit format, the lines carry one code group per clock: bits 3..0 and bit 4 on the rising half, bits 8..5 and bit 9 on the falling half. A speed input selects the 10/100 case of the byte format. In that case only the rising-half nibble is used, and two consecutive nibbles are joined into one byte. The format and speed inputs take effect only between frames.

Both output streams are valid-only and have no ready input. The physical link cannot be paused, so downstream logic must accept every word in the cycle it is strobed. There is no back-pressure and no buffering.

Top module: `rx_ddr_capture`

## Requirements
- R1: An active-high synchronous reset clears all captured samples and the selection state (byte format, full rate). On the cycle after a reset edge, byte_valid_o, byte_err_o, carrier_o and code_valid_o are all low.
- R2: In byte format at full rate, a pair whose rising control sample is high produces byte_o = {falling nibble, rising nibble}, with bits 3..0 taken from the rising edge, and byte_valid_o high for that cycle.
- R3: The error flag of a pair is the rising control sample XOR the falling control sample. byte_err_o is high only together with byte_valid_o.
- R4: In byte format, a pair with a low rising control sample and a high error flag raises carrier_o. In that cycle byte_valid_o is low and byte_o is zero.
- R5: In byte format at 10/100 rate, only rising-edge nibbles are used. Two consecutive valid nibbles form one byte, the first nibble in bits 3..0. byte_valid_o strobes for one cycle per byte, and byte_err_o is set if either nibble had its error flag. A lone nibble at the end of a frame is dropped.
- R6: In ten-bit format, code_o = {fall ctl, fall nibble, rise ctl, rise nibble}, so that bit 4 is the rising control sample and bit 9 is the falling control sample. code_valid_o is high on every cycle. The byte outputs stay low.
- R7: In byte format, a new format or speed selection is taken only at a rising edge where the pair being emitted has a low rising control sample, so a frame is never split across settings. In ten-bit format a new selection is taken at every edge.
- R8: A pair is presented one cycle after its rising sample: its word appears after the first rising edge that follows its falling sample, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the link |
| rst | input | 1 | Synchronous reset, active high |
| tbi_sel_i | input | 1 | 1 selects the ten-bit code format, 0 the byte format |
| slow_sel_i | input | 1 | 1 selects 10/100 nibble assembly in byte format |
| rx_nib_i | input | 4 | Data lines, sampled on both clock edges |
| rx_ctl_i | input | 1 | Control line, sampled on both clock edges |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| byte_err_o | output | 1 | Error qualifier for the strobed byte |
| carrier_o | output | 1 | Carrier/idle indication outside a frame |
| code_o | output | 10 | Received ten-bit code group |
| code_valid_o | output | 1 | Strobe for code_o |

## Verification
Two functions can fall in the same cycle: a format or speed change can be requested in the very cycle a frame's last valid pair is emitted. The bench raises the ten-bit selection in the middle of a byte frame and then ends the frame. It expects byte words to continue until the last pair, and expects code words to start only after the first pair with low data-valid has passed. A reference model in the bench repeats this decision on every clock, both for random format and speed toggles and for random traffic. It also covers a reset asserted in the middle of a frame.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;
  localparam int unsigned NIB_W_DEF = 4;

  typedef enum logic {
    FMT_BYTE = 1'b0,
    FMT_CODE = 1'b1
  } fmt_e;
endpackage

// File: rtl/rxcap_ddr_sampler.sv
module rxcap_ddr_sampler #(
  parameter int unsigned NIB_W = rxcap_pkg::NIB_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             ctl_i,
  output logic [NIB_W-1:0] rise_d_o,
  output logic             rise_c_o,
  output logic [NIB_W-1:0] fall_d_o,
  output logic             fall_c_o
);
  localparam int unsigned LANES = NIB_W + 1;

  logic [LANES-1:0] lane_in;
  logic [LANES-1:0] rise_w;
  logic [LANES-1:0] fall_w;

  assign lane_in = {ctl_i, nib_i};

  // one rising and one falling capture flop per line
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic r_q;
    logic f_q;

    always_ff @(posedge clk) begin
      if (rst) r_q <= 1'b0;
      else     r_q <= lane_in[g];
    end

    always_ff @(negedge clk) begin
      if (rst) f_q <= 1'b0;
      else     f_q <= lane_in[g];
    end

    assign rise_w[g] = r_q;
    assign fall_w[g] = f_q;
  end

  assign rise_d_o = rise_w[NIB_W-1:0];
  assign rise_c_o = rise_w[NIB_W];
  assign fall_d_o = fall_w[NIB_W-1:0];
  assign fall_c_o = fall_w[NIB_W];
endmodule

// File: rtl/rxcap_fmt_lock.sv
module rxcap_fmt_lock (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbi_sel_i,
  input  logic              slow_sel_i,
  input  logic              dv_sample_i,
  output rxcap_pkg::fmt_e   fmt_o,
  output logic              slow_o
);
  import rxcap_pkg::*;

  fmt_e fmt_q;
  logic slow_q;
  logic in_frame;

  // a byte-format pair with data-valid high holds the current setting
  assign in_frame = (fmt_q == FMT_BYTE) && dv_sample_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= FMT_BYTE;
      slow_q <= 1'b0;
    end else if (!in_frame) begin
      fmt_q  <= fmt_e'(tbi_sel_i);
      slow_q <= slow_sel_i;
    end
  end

  assign fmt_o  = fmt_q;
  assign slow_o = slow_q;

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((fmt_q == FMT_BYTE) && dv_sample_i) |=> ($stable(fmt_q) && $stable(slow_q)));
endmodule

// File: rtl/rxcap_byte_dec.sv
module rxcap_byte_dec #(
  parameter int unsigned NIB_W = rxcap_pkg::NIB_W_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              slow_i,
  input  logic [NIB_W-1:0]  rise_d_i,
  input  logic              rise_c_i,
  input  logic [NIB_W-1:0]  fall_d_i,
  input  logic              fall_c_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic              err_o,
  output logic              carrier_o
);
  logic             dv;
  logic             er_line;
  logic             half_q;
  logic [NIB_W-1:0] lo_q;
  logic             erracc_q;

  assign dv      = rise_c_i;
  assign er_line = rise_c_i ^ fall_c_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      byte_o    <= '0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      carrier_o <= 1'b0;
      half_q    <= 1'b0;
      lo_q      <= '0;
      erracc_q  <= 1'b0;
    end else begin
      byte_o    <= '0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      carrier_o <= 1'b0;
      if (!dv) begin
        // outside a frame: drop any pending nibble, report carrier/idle
        half_q    <= 1'b0;
        carrier_o <= er_line;
      end else if (!slow_i) begin
        half_q  <= 1'b0;
        valid_o <= 1'b1;
        byte_o  <= {fall_d_i, rise_d_i};
        err_o   <= er_line;
      end else if (!half_q) begin
        half_q   <= 1'b1;
        lo_q     <= rise_d_i;
        erracc_q <= er_line;
      end else begin
        half_q  <= 1'b0;
        valid_o <= 1'b1;
        byte_o  <= {rise_d_i, lo_q};
        err_o   <= er_line | erracc_q;
      end
    end
  end

  // R3
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> valid_o);

  // R4
  carrier_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    carrier_o |-> (!valid_o && (byte_o == '0)));

  // R5
  slow_strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (slow_i && valid_o) |=> !valid_o);
endmodule

// File: rtl/rxcap_code_asm.sv
module rxcap_code_asm #(
  parameter int unsigned NIB_W = rxcap_pkg::NIB_W_DEF,
  localparam int unsigned CODE_W = 2 * NIB_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [NIB_W-1:0]  rise_d_i,
  input  logic              rise_c_i,
  input  logic [NIB_W-1:0]  fall_d_i,
  input  logic              fall_c_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      code_o  <= {fall_c_i, fall_d_i, rise_c_i, rise_d_i};
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_ddr_capture.sv
module rx_ddr_capture #(
  parameter int unsigned NIB_W = rxcap_pkg::NIB_W_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W,
  localparam int unsigned CODE_W = 2 * NIB_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbi_sel_i,
  input  logic              slow_sel_i,
  input  logic [NIB_W-1:0]  rx_nib_i,
  input  logic              rx_ctl_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              byte_err_o,
  output logic              carrier_o,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o
);
  import rxcap_pkg::*;

  logic [NIB_W-1:0] rise_d;
  logic             rise_c;
  logic [NIB_W-1:0] fall_d;
  logic             fall_c;
  fmt_e             fmt;
  logic             slow;

  rxcap_ddr_sampler #(.NIB_W(NIB_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .nib_i    (rx_nib_i),
    .ctl_i    (rx_ctl_i),
    .rise_d_o (rise_d),
    .rise_c_o (rise_c),
    .fall_d_o (fall_d),
    .fall_c_o (fall_c)
  );

  rxcap_fmt_lock u_lock (
    .clk         (clk),
    .rst         (rst),
    .tbi_sel_i   (tbi_sel_i),
    .slow_sel_i  (slow_sel_i),
    .dv_sample_i (rise_c),
    .fmt_o       (fmt),
    .slow_o      (slow)
  );

  rxcap_byte_dec #(.NIB_W(NIB_W)) u_byte (
    .clk       (clk),
    .rst       (rst),
    .en_i      (fmt == FMT_BYTE),
    .slow_i    (slow),
    .rise_d_i  (rise_d),
    .rise_c_i  (rise_c),
    .fall_d_i  (fall_d),
    .fall_c_i  (fall_c),
    .byte_o    (byte_o),
    .valid_o   (byte_valid_o),
    .err_o     (byte_err_o),
    .carrier_o (carrier_o)
  );

  rxcap_code_asm #(.NIB_W(NIB_W)) u_code (
    .clk      (clk),
    .rst      (rst),
    .en_i     (fmt == FMT_CODE),
    .rise_d_i (rise_d),
    .rise_c_i (rise_c),
    .fall_d_i (fall_d),
    .fall_c_i (fall_c),
    .code_o   (code_o),
    .valid_o  (code_valid_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!byte_valid_o && !byte_err_o && !carrier_o && !code_valid_o));

  // R6
  stream_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    code_valid_o |-> (!byte_valid_o && !carrier_o));
endmodule

// File: tb/tb_rx_ddr_capture.sv
`timescale 1ns/1ps
module tb_rx_ddr_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbi_sel = 1'b0;
  logic       slow_sel = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       rxctl = 1'b0;
  logic [7:0] byte_o;
  logic       byte_valid_o, byte_err_o, carrier_o, code_valid_o;
  logic [9:0] code_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_ddr_capture dut (
    .clk(clk), .rst(rst), .tbi_sel_i(tbi_sel), .slow_sel_i(slow_sel),
    .rx_nib_i(rxd), .rx_ctl_i(rxctl),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .byte_err_o(byte_err_o),
    .carrier_o(carrier_o), .code_o(code_o), .code_valid_o(code_valid_o)
  );

  // ---------------- reference model ----------------
  logic [3:0] m_rn = 0, m_fn = 0;
  logic       m_rc = 0, m_fc = 0;
  logic       m_tbi = 0, m_slow = 0;
  logic [4:0] nq[$];
  logic [7:0] e_byte;
  logic [9:0] e_code;
  logic       e_bv, e_err, e_car, e_cv;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin m_fn = 0; m_fc = 0; end
    else begin m_fn = rxd; m_fc = rxctl; end
  end

  always @(posedge clk) begin
    logic er;
    e_byte = 0; e_code = 0; e_bv = 0; e_err = 0; e_car = 0; e_cv = 0;
    if (rst) begin
      nq.delete();
      m_tbi = 0; m_slow = 0; m_rn = 0; m_rc = 0;
    end else begin
      er = m_rc ^ m_fc;
      if (m_tbi) begin
        e_code = {m_fc, m_fn, m_rc, m_rn};
        e_cv = 1;
        nq.delete();
      end else if (!m_rc) begin
        nq.delete();
        e_car = er;
      end else if (!m_slow) begin
        e_bv = 1; e_byte = {m_fn, m_rn}; e_err = er;
      end else begin
        nq.push_back({er, m_rn});
        if (nq.size() == 2) begin
          e_bv = 1;
          e_byte = {nq[1][3:0], nq[0][3:0]};
          e_err = nq[0][4] | nq[1][4];
          nq.delete();
        end
      end
      if (m_tbi || !m_rc) begin m_tbi = tbi_sel; m_slow = slow_sel; end
      m_rn = rxd; m_rc = rxctl;
    end
    #1;
    if (!done) begin
      if (m_slow && !m_tbi) begin
        chk("R5 byte", byte_o, e_byte);
        chk("R5 strobe", byte_valid_o, e_bv);
      end else begin
        chk("R2 R8 byte", byte_o, e_byte);
        chk("R2 R8 strobe", byte_valid_o, e_bv);
      end
      chk("R3 err", byte_err_o, e_err);
      chk("R4 carrier", carrier_o, e_car);
      chk("R6 code", code_o, e_code);
      chk("R6 code strobe", code_valid_o, e_cv);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [3:0] rn, input logic rc,
                       input logic [3:0] fn, input logic fc);
    @(negedge clk); #1; rxd = rn; rxctl = rc;
    @(posedge clk); #1; rxd = fn; rxctl = fc;
  endtask

  task automatic rg_byte(input logic [7:0] b, input logic dv, input logic er);
    drive(b[3:0], dv, b[7:4], dv ^ er);
  endtask

  task automatic rg_nib(input logic [3:0] n, input logic dv, input logic er);
    drive(n, dv, n, dv ^ er);
  endtask

  task automatic tbi_code(input logic [9:0] c);
    drive(c[3:0], c[4], c[8:5], c[9]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) rg_byte(8'h00, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", byte_valid_o, 0);
    chk("R1 code strobe", code_valid_o, 0);
    chk("R1 carrier", carrier_o, 0);
    #1 rst = 1'b0;
    idle(2);

    // R2, R8: full-rate bytes; word must not appear early
    rg_byte(8'h3C, 1, 0);
    chk("R8 not early", byte_valid_o, 0);
    rg_byte(8'hD5, 1, 0);
    chk("R8 byte", byte_o, 8'h3C);
    chk("R2 strobe", byte_valid_o, 1);
    rg_byte(8'hA3, 1, 1);               // R3 error inside a frame
    rg_byte(8'h0F, 1, 0);
    chk("R3 err", byte_err_o, 1);
    idle(2);

    // R4 carrier indication
    rg_byte(8'h0E, 0, 1);
    rg_byte(8'h0E, 0, 1);
    chk("R4 carrier", carrier_o, 1);
    chk("R4 no strobe", byte_valid_o, 0);
    idle(2);

    // R5 slow mode, odd-length frame with an error nibble
    @(negedge clk); #1 slow_sel = 1'b1;
    idle(3);
    rg_nib(4'h5, 1, 0); rg_nib(4'hD, 1, 0);
    rg_nib(4'hA, 1, 1); rg_nib(4'h3, 1, 0);
    rg_nib(4'h7, 1, 0);
    chk("R5 err from low nibble", byte_err_o, 1);
    chk("R5 byte", byte_o, 8'h3A);
    idle(3);
    chk("R5 lone nibble dropped", byte_valid_o, 0);
    @(negedge clk); #1 slow_sel = 1'b0;
    idle(2);

    // R7 format request in the middle of a frame
    rg_byte(8'h11, 1, 0);
    @(negedge clk); #1 tbi_sel = 1'b1;
    rg_byte(8'h22, 1, 0);
    rg_byte(8'h33, 1, 0);
    chk("R7 held in frame", code_valid_o, 0);
    chk("R7 bytes continue", byte_valid_o, 1);
    idle(3);
    chk("R7 switched after frame", code_valid_o, 1);

    // R6 code groups
    tbi_code(10'h17C); tbi_code(10'h283);
    chk("R6 code", code_o, 10'h17C);
    tbi_code(10'h3FF); tbi_code(10'h000);
    tbi_code(10'h210);
    chk("R6 byte quiet", byte_valid_o, 0);
    @(negedge clk); #1 tbi_sel = 1'b0;
    idle(3);

    // random traffic with random format and speed toggles
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 40) == 0) begin
        @(negedge clk); #1;
        tbi_sel = ($urandom % 4) == 0;
        slow_sel = $urandom % 2;
      end
      drive($urandom, ($urandom % 5) != 0, $urandom, $urandom);
    end

    // R1 reset in the middle of a frame
    @(negedge clk); #1 tbi_sel = 1'b0; slow_sel = 1'b0;
    rg_byte(8'h44, 1, 0);
    @(negedge clk); #1 rst = 1'b1;
    rg_byte(8'h55, 1, 0);
    chk("R1 mid-frame valid", byte_valid_o, 0);
    chk("R1 mid-frame code", code_valid_o, 0);
    @(negedge clk); #1 rst = 1'b0;
    rg_byte(8'h66, 1, 0);
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule